// File: doc/BRIEF.md
# Capture Request Handshake Across Two Clock Domains

This block carries a single-cycle capture request from a slow control clock domain into a fast sampling clock domain. It then carries the "acquisition running" state back again, and it sequences the slow-domain readout of the captured samples. The slow side holds the request as a level until the fast side answers. The fast side sees that level through a two-flop synchronizer and runs a write-address counter over one full memory depth. Its acquiring flag returns through a second two-flop synchronizer. That returned flag clears the pending request and starts the readout.

During readout the read address steps once for each cycle in which the downstream transmitter reports that it is idle. The same strobe that starts a transmission also serves as the memory read enable. The sample memory, the serializer and any trigger logic sit outside this block. It only drives their address, write-enable and read-enable pins.

Top module: `cap_hs_top`

## Requirements
- R1: A one-cycle pulse on `cap_req_i` while the block is idle raises `req_pending_o` on the next control clock edge. `req_pending_o` stays high until the returned acquiring flag is seen in the control domain.
- R2: The sampling domain raises `acq_o` only after the pending request has passed through a two-flop synchronizer. While `acq_o` is high, `wr_addr_o` starts at 0 and increases by one on every sampling clock.
- R3: An acquisition lasts exactly 2^ADDR_W sampling cycles (512 by default). `acq_o` falls after the cycle that writes the all-ones address, and `wr_addr_o` wraps back to 0.
- R4: `acq_o` returns to the control domain through two flops, and the returned level clears `req_pending_o`. The pending flag never drops while `acq_o` is low.
- R5: Readout begins on the rising edge of the returned acquiring flag. `readout_o` goes high and `rd_addr_o` starts at 0.
- R6: `tx_start_o` is high exactly when a readout is active and `tx_busy_i` is low. `rd_addr_o` holds its value in every cycle without a strobe and advances by one after each strobe. Each strobe presents the next address in sequence.
- R7: A readout ends after the strobe that carries the all-ones address. It gives exactly 2^ADDR_W strobes, after which `readout_o` is low and `rd_addr_o` is 0.
- R8: A request pulse is ignored, and starts no new acquisition, while a request is pending, while the returned acquiring flag is visible, or while a readout is active.
- R9: `rst_ctl` clears the control-domain flags and the read address. `rst_smp` clears the acquiring flag and the write address. Both resets are active-high and synchronous to their own clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Slow control clock |
| rst_ctl | input | 1 | Active-high synchronous reset, control domain |
| cap_req_i | input | 1 | One-cycle capture request |
| tx_busy_i | input | 1 | Transmitter busy; readout waits while high |
| req_pending_o | output | 1 | Held request flag |
| readout_o | output | 1 | Readout in progress |
| tx_start_o | output | 1 | Transmit start strobe and memory read enable |
| rd_addr_o | output | ADDR_W | Memory read address |
| clk_smp | input | 1 | Fast sampling clock |
| rst_smp | input | 1 | Active-high synchronous reset, sampling domain |
| acq_o | output | 1 | Acquiring flag, used as memory write enable |
| wr_addr_o | output | ADDR_W | Memory write address |

## Verification
The assertions assume that `cap_req_i` is a single-cycle pulse. They also assume that an acquisition of 2^ADDR_W sampling cycles finishes well before a readout of 2^ADDR_W control cycles can, so the returned flag has fallen before the block is idle again. The stimulus keeps the sampling clock faster than the control clock. It issues requests only as one-cycle pulses and leaves `tx_busy_i` free to take any pattern, since the readout must tolerate every busy sequence. Resets are applied to both domains together, so neither side is left holding a handshake level that the other has dropped.

// File: rtl/cap_hs_pkg.sv
package cap_hs_pkg;
  // Next address in a w-bit wrapping counter.
  function automatic logic [31:0] addr_next(input logic [31:0] a, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (a + 32'd1) & mask;
  endfunction

  // True when a w-bit address is the last slot of the memory.
  function automatic logic addr_is_last(input logic [31:0] a, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (a & mask) == mask;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_acq.sv
module cap_acq
  import cap_hs_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_seen,
  output logic              acq_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic              acq_q;
  logic [ADDR_W-1:0] wr_q;
  logic              wr_last;

  assign wr_last = addr_is_last(32'(wr_q), ADDR_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_q <= 1'b0;
      wr_q  <= '0;
    end else if (!acq_q) begin
      acq_q <= req_seen;
    end else begin
      wr_q <= ADDR_W'(addr_next(32'(wr_q), ADDR_W));
      if (wr_last) acq_q <= 1'b0;
    end
  end

  assign acq_o     = acq_q;
  assign wr_addr_o = wr_q;

  // R3
  acq_len_chk: assert property (@(posedge clk) disable iff (rst)
    acq_q && !wr_last |=> acq_q);
  // R3
  acq_stop_chk: assert property (@(posedge clk) disable iff (rst)
    acq_q && wr_last |=> !acq_q && wr_q == '0);
  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    acq_q |=> wr_q == ADDR_W'($past(wr_q) + 1'b1));
  // R2
  acq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !acq_q && !req_seen |=> !acq_q);
endmodule

// File: rtl/cap_ctl.sv
module cap_ctl
  import cap_hs_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_pulse,
  input  logic              ack_seen,
  input  logic              tx_busy,
  output logic              req_flag_o,
  output logic              reading_o,
  output logic              tx_start_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic              req_q, ack_q, rd_q;
  logic [ADDR_W-1:0] ra_q;
  logic              idle, ack_rise, strobe, rd_last;

  assign idle     = !req_q && !ack_seen && !rd_q;
  assign ack_rise = ack_seen && !ack_q;
  assign strobe   = rd_q && !tx_busy;
  assign rd_last  = addr_is_last(32'(ra_q), ADDR_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      rd_q  <= 1'b0;
      ra_q  <= '0;
    end else begin
      ack_q <= ack_seen;
      if (req_q) begin
        if (ack_seen) req_q <= 1'b0;
      end else if (req_pulse && idle) begin
        req_q <= 1'b1;
      end
      if (!rd_q) begin
        if (ack_rise) begin
          rd_q <= 1'b1;
          ra_q <= '0;
        end
      end else if (strobe) begin
        ra_q <= ADDR_W'(addr_next(32'(ra_q), ADDR_W));
        if (rd_last) rd_q <= 1'b0;
      end
    end
  end

  assign req_flag_o = req_q;
  assign reading_o  = rd_q;
  assign tx_start_o = strobe;
  assign rd_addr_o  = ra_q;

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_q && !ack_seen |=> req_q);
  // R4
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    req_q && ack_seen |=> !req_q);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(ra_q));
  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !tx_start_o);
  // R7
  rd_end_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && rd_last |=> !rd_q && ra_q == '0);
  // R8
  req_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    rd_q && req_pulse |=> !req_q);
endmodule

// File: rtl/cap_hs_top.sv
module cap_hs_top
  import cap_hs_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_ctl,
  input  logic              rst_ctl,
  input  logic              cap_req_i,
  input  logic              tx_busy_i,
  output logic              req_pending_o,
  output logic              readout_o,
  output logic              tx_start_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              clk_smp,
  input  logic              rst_smp,
  output logic              acq_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic req_level, req_in_smp;
  logic acq_level, acq_in_ctl;

  cap_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk_ctl),
    .rst        (rst_ctl),
    .req_pulse  (cap_req_i),
    .ack_seen   (acq_in_ctl),
    .tx_busy    (tx_busy_i),
    .req_flag_o (req_level),
    .reading_o  (readout_o),
    .tx_start_o (tx_start_o),
    .rd_addr_o  (rd_addr_o)
  );

  cap_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk (clk_smp),
    .rst (rst_smp),
    .d   (req_level),
    .q   (req_in_smp)
  );

  cap_acq #(.ADDR_W(ADDR_W)) u_acq (
    .clk       (clk_smp),
    .rst       (rst_smp),
    .req_seen  (req_in_smp),
    .acq_o     (acq_level),
    .wr_addr_o (wr_addr_o)
  );

  cap_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk (clk_ctl),
    .rst (rst_ctl),
    .d   (acq_level),
    .q   (acq_in_ctl)
  );

  assign req_pending_o = req_level;
  assign acq_o         = acq_level;
endmodule

// File: tb/test_cap_hs_top.sv
`timescale 1ns/1ps
module test_cap_hs_top;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk_ctl = 1'b0, clk_smp = 1'b0;
  logic rst_ctl = 1'b1, rst_smp = 1'b1;
  logic cap_req = 1'b0, tx_busy = 1'b0;
  logic req_pending, readout, tx_start, acq;
  logic [AW-1:0] rd_addr, wr_addr;

  always #5   clk_ctl = ~clk_ctl;   // 100 MHz control clock
  always #1.5 clk_smp = ~clk_smp;   // faster sampling clock

  cap_hs_top #(.ADDR_W(AW)) i_cap_hs_top (
    .clk_ctl(clk_ctl), .rst_ctl(rst_ctl), .cap_req_i(cap_req), .tx_busy_i(tx_busy),
    .req_pending_o(req_pending), .readout_o(readout), .tx_start_o(tx_start),
    .rd_addr_o(rd_addr), .clk_smp(clk_smp), .rst_smp(rst_smp),
    .acq_o(acq), .wr_addr_o(wr_addr)
  );

  int n_checks = 0, n_fail = 0;
  int exp_wr = 0, n_wr = 0, wr_err = 0;
  int exp_rd = 0, n_tx = 0, rd_err = 0, busy_err = 0, hold_err = 0, drop_err = 0;
  int busy_mode = 0, bcnt = 0;
  logic prev_pend = 1'b0, prev_strobe = 1'b0;
  logic [AW-1:0] prev_rd = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Busy pattern generator, driven just after the control edge.
  always @(posedge clk_ctl) begin
    #1;
    bcnt++;
    case (busy_mode)
      1:       tx_busy = (bcnt % 3) != 0;
      2:       tx_busy = ((bcnt >> 4) & 1) == 1;
      default: tx_busy = 1'b0;
    endcase
  end

  // Write-side monitor (R2, R3).
  always @(negedge clk_smp) begin
    if (!rst_smp && acq) begin
      if (wr_addr != AW'(exp_wr)) wr_err++;
      exp_wr = (exp_wr + 1) % DEPTH;
      n_wr++;
    end
  end

  // Read-side monitor (R4, R6, R7).
  always @(negedge clk_ctl) begin
    if (!rst_ctl) begin
      if (tx_start) begin
        if (rd_addr != AW'(exp_rd)) rd_err++;
        exp_rd = (exp_rd + 1) % DEPTH;
        n_tx++;
      end
      if (tx_start != (readout && !tx_busy)) busy_err++;
      if (!prev_strobe && rd_addr != prev_rd) hold_err++;
      if (prev_pend && !req_pending && !acq) drop_err++;
    end
    prev_pend   = req_pending;
    prev_strobe = tx_start;
    prev_rd     = rd_addr;
  end

  task automatic clear_counts();
    exp_wr = 0; n_wr = 0; wr_err = 0;
    exp_rd = 0; n_tx = 0; rd_err = 0; busy_err = 0; hold_err = 0; drop_err = 0;
  endtask

  task automatic pulse_req();
    @(posedge clk_ctl); #1 cap_req = 1'b1;
    @(posedge clk_ctl); #1 cap_req = 1'b0;
  endtask

  task automatic wait_ctl(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_ctl);
  endtask

  task automatic check_idle(input string req);
    @(negedge clk_ctl);
    check(!req_pending, req, req_pending, 0);
    check(!readout,     req, readout, 0);
    check(!tx_start,    req, tx_start, 0);
    check(rd_addr == 0, req, rd_addr, 0);
    check(!acq,         req, acq, 0);
    check(wr_addr == 0, req, wr_addr, 0);
  endtask

  task automatic do_reset();
    @(posedge clk_ctl); #1 rst_ctl = 1'b1; rst_smp = 1'b1;
    wait_ctl(4);
    #1 rst_ctl = 1'b0; rst_smp = 1'b0;
    clear_counts();
  endtask

  // Scenario: reset state (R9).
  task automatic t_reset();
    do_reset();
    check_idle("R9 reset state");
  endtask

  // Scenario: one full capture and readout under a given busy pattern.
  task automatic t_capture(input int mode, input bit poke_during_readout);
    int guard;
    busy_mode = mode;
    clear_counts();
    pulse_req();
    @(negedge clk_ctl);
    check(req_pending, "R1 request held", req_pending, 1);
    guard = 0;
    while (!acq && guard < 20) begin @(negedge clk_ctl); guard++; end
    check(acq, "R2 acquisition started", acq, 1);
    check(req_pending || acq, "R1 held until reply", req_pending, 1);
    guard = 0;
    while (!readout && guard < 20) begin @(negedge clk_ctl); guard++; end
    check(readout, "R5 readout started", readout, 1);
    check(!req_pending, "R4 reply cleared request", req_pending, 0);
    if (poke_during_readout) begin
      wait_ctl(5);
      pulse_req();
      @(negedge clk_ctl);
      check(!req_pending, "R8 request ignored during readout", req_pending, 0);
    end
    guard = 0;
    while (readout && guard < 8 * DEPTH) begin @(negedge clk_ctl); guard++; end
    check(!readout, "R7 readout finished", readout, 0);
    wait_ctl(40);
    @(negedge clk_ctl);
    check(n_wr == DEPTH, "R3 acquisition length", n_wr, DEPTH);
    check(wr_err == 0,   "R2 write address sequence", wr_err, 0);
    check(!acq && wr_addr == 0, "R3 write address wrapped", wr_addr, 0);
    check(n_tx == DEPTH, "R7 strobe count", n_tx, DEPTH);
    check(rd_err == 0,   "R6 read address sequence", rd_err, 0);
    check(busy_err == 0, "R6 strobe follows busy", busy_err, 0);
    check(hold_err == 0, "R6 address held without strobe", hold_err, 0);
    check(drop_err == 0, "R4 request kept until reply", drop_err, 0);
    check(rd_addr == 0 && !req_pending, "R7 read address wrapped", rd_addr, 0);
  endtask

  // Scenario: back-to-back pulses while the first request is pending (R8).
  task automatic t_double_pulse();
    busy_mode = 0;
    clear_counts();
    @(posedge clk_ctl); #1 cap_req = 1'b1;
    wait_ctl(3);
    #1 cap_req = 1'b0;
    wait_ctl(4 * DEPTH);
    @(negedge clk_ctl);
    check(n_wr == DEPTH, "R8 extra pulses while pending ignored", n_wr, DEPTH);
    check(n_tx == DEPTH, "R8 single readout", n_tx, DEPTH);
  endtask

  // Scenario: reset in the middle of an acquisition (R9).
  task automatic t_reset_mid();
    int guard;
    busy_mode = 0;
    clear_counts();
    pulse_req();
    guard = 0;
    while (!acq && guard < 20) begin @(negedge clk_ctl); guard++; end
    do_reset();
    check_idle("R9 reset mid acquisition");
    wait_ctl(20);
    @(negedge clk_ctl);
    check(!acq && !readout, "R9 stays idle after reset", acq, 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_capture(0, 1'b0);
    t_capture(1, 1'b1);
    t_capture(2, 1'b0);
    t_double_pulse();
    t_reset_mid();
    t_capture(1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule